// File: doc/BRIEF.md
# Multi-width ALU with condition-code register

This block performs integer arithmetic and bitwise logic on 8-, 16- or 32-bit operands and keeps a four-flag condition-code register (negative, zero, overflow, carry). Each cycle it may accept one operation. The inputs are an operation code, an operand size, two 32-bit operands and a write-enable flag. One clock edge later the block presents a registered result, a one-cycle store strobe and the updated flags. The flag rules depend on the operation class. Add and subtract compute carry and overflow. Increment and decrement compute overflow from the prior value and leave carry alone. Bitwise operations clear overflow. Compare writes only the flags.

Three immediate operations use the condition-code register itself as their destination. The four flags are widened to a byte, combined with the low byte of the second operand, and the low nibble of the result becomes the new flag set. A combinational branch evaluator reads the registered flags and reports whether a selected condition holds. A decoder uses this to resolve conditional branches. Operand fetch, addressing and memory access belong to neighbouring blocks.

The block has no control state machine. Its only state is the result register, the strobe register and the flag register, all updated from one registered process.

Top module: `alu_ccr`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `store` is 0 and `ccr` is 0.
- R2: Operation codes are 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 increment, 7 decrement, 8 flag-AND, 9 flag-OR and 10 flag-XOR. An operation presented with `op_valid` high at a rising edge updates `result`, `store` and `ccr` at that edge. With `op_valid` low, `result` and `ccr` hold their values and `store` is 0.
- R3: `op_size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected width are ignored. Result bits above it are 0. N is the top bit of the result at the selected width. For every arithmetic and bitwise operation, Z is set exactly when that result is zero. `ccr` packs N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R4: Add returns a+b. V is set when both operands have equal sign bits and the sign bit of the result differs from them. For 8 and 16 bits, C is the bit just above the width in the full sum. For 32 bits, C is set when the result is unsigned-less-than either operand.
- R5: Subtract returns a-b. C is set when a is unsigned-less-than b at the selected width. V is set when the operand sign bits differ and the sign bit of the result differs from that of a.
- R6: Compare sets the flags and `result` exactly as subtract does, and never raises `store`.
- R7: Increment returns a+b and decrement returns a-b, with b as the step. Both keep C. V is set when every bit of a below its sign bit is 1.
- R8: AND, OR and XOR set N and Z from the result, clear V and keep C.
- R9: `store` is high for exactly one cycle after a valid add, subtract, bitwise, increment or decrement operation with `wr_en` high, and is low otherwise.
- R10: The flag-AND, flag-OR and flag-XOR operations combine the byte {0000, N, Z, V, C} with `opnd_b[7:0]`. Bits 3..0 of the combined byte become N, Z, V and C. `result` takes the zero-extended byte, and `store` stays low.
- R11: `br_taken` follows the registered flags combinationally for `cond_sel`: 0 always, 1 never, 2 Z, 3 not Z, 4 (Z or (N xor V)) = 0, 5 (Z or (N xor V)) = 1, 6 C, 7 not C.
- R12: Operation codes 11 to 15 with `op_valid` high leave `result` and `ccr` unchanged and keep `store` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector |
| op_size | input | 2 | Operand width selector |
| wr_en | input | 1 | Allows the result store strobe |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, step or flag immediate |
| cond_sel | input | 3 | Branch condition selector |
| result | output | 32 | Registered result |
| store | output | 1 | One-cycle result store strobe |
| ccr | output | 4 | Registered flags N,Z,V,C |
| br_taken | output | 1 | Selected condition holds |

## Verification
`result`, `store` and `ccr` are registered, so each one responds at the rising edge that accepts the operation. `br_taken` follows `ccr` with no further delay. The bench changes inputs on the falling edge and holds `op_valid` for one cycle. It reads all outputs at the next falling edge, half a cycle after the edge that loaded them. One further falling edge later it confirms that `store` has fallen and that idle cycles leave the state unchanged. Every flag value the bench expects is worked out by hand from the rules above, and the tests run in a chosen order so that each kept carry flag starts from a known value.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_CMP   = 4'd2,
        OP_AND   = 4'd3,
        OP_OR    = 4'd4,
        OP_XOR   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_CCAND = 4'd8,
        OP_CCOR  = 4'd9,
        OP_CCXOR = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONGX = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        CND_ALWAYS = 3'd0,
        CND_NEVER  = 3'd1,
        CND_EQ     = 3'd2,
        CND_NE     = 3'd3,
        CND_GT     = 3'd4,
        CND_LE     = 3'd5,
        CND_CS     = 3'd6,
        CND_CC     = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/alu_ccr_lane.sv
module alu_ccr_lane
    import alu_ccr_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   res,
    output ccr_t           flg
);
    localparam int MSB = W - 1;
    localparam logic [W-1:0] LOW_ONES = {1'b0, {(W-1){1'b1}}};

    logic [W:0] sum_x;
    logic [W:0] dif_x;
    logic       add_c;

    assign sum_x = {1'b0, a} + {1'b0, b};
    assign dif_x = {1'b0, a} - {1'b0, b};

    if (W >= 32) begin : g_wide_carry
        assign add_c = (sum_x[W-1:0] < a) || (sum_x[W-1:0] < b);
    end else begin : g_narrow_carry
        assign add_c = sum_x[W];
    end

    always_comb begin
        res   = '0;
        flg.v = 1'b0;
        flg.c = c_in;
        case (op)
            OP_ADD: begin
                res   = sum_x[W-1:0];
                flg.v = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
                flg.c = add_c;
            end
            OP_SUB, OP_CMP: begin
                res   = dif_x[W-1:0];
                flg.v = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
                flg.c = a < b;
            end
            OP_INC: begin
                res   = sum_x[W-1:0];
                flg.v = (a & LOW_ONES) == LOW_ONES;
            end
            OP_DEC: begin
                res   = dif_x[W-1:0];
                flg.v = (a & LOW_ONES) == LOW_ONES;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            default: res = '0;
        endcase
        flg.n = res[MSB];
        flg.z = (res == '0);
    end

endmodule

// File: rtl/alu_ccr_core.sv
module alu_ccr_core
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BASE_W = 8,
    parameter int LANES  = 3
) (
    input  alu_op_e             op,
    input  size_e               size,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  ccr_t                ccr_in,
    output logic [DATA_W-1:0]   res,
    output ccr_t                ccr_nxt,
    output logic                known,
    output logic                stores
);
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int IMM_W = 8;

    logic [DATA_W-1:0] lane_res [LANES];
    ccr_t              lane_flg [LANES];
    logic [SEL_W-1:0]  sel;
    logic [IMM_W-1:0]  cc_src;
    logic [IMM_W-1:0]  cc_byte;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int LW = BASE_W << gi;
        logic [LW-1:0] lane_r;
        alu_ccr_lane #(.W(LW)) u_lane (
            .op   (op),
            .a    (a[LW-1:0]),
            .b    (b[LW-1:0]),
            .c_in (ccr_in.c),
            .res  (lane_r),
            .flg  (lane_flg[gi])
        );
        assign lane_res[gi] = DATA_W'(lane_r);
    end

    always_comb begin
        case (size)
            SZ_BYTE: sel = SEL_W'(0);
            SZ_WORD: sel = SEL_W'(1);
            default: sel = SEL_W'(LANES - 1);
        endcase
    end

    assign cc_src = {{(IMM_W-4){1'b0}}, ccr_in};

    always_comb begin
        known   = 1'b1;
        stores  = 1'b0;
        res     = lane_res[sel];
        ccr_nxt = lane_flg[sel];
        cc_byte = cc_src;
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                stores = 1'b1;
            end
            OP_CMP: begin
                stores = 1'b0;
            end
            OP_CCAND, OP_CCOR, OP_CCXOR: begin
                if (op == OP_CCAND)
                    cc_byte = cc_src & b[IMM_W-1:0];
                else if (op == OP_CCOR)
                    cc_byte = cc_src | b[IMM_W-1:0];
                else
                    cc_byte = cc_src ^ b[IMM_W-1:0];
                res     = DATA_W'(cc_byte);
                ccr_nxt = ccr_t'(cc_byte[3:0]);
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_ccr_cond.sv
module alu_ccr_cond
    import alu_ccr_pkg::*;
(
    input  ccr_t   flags,
    input  cond_e  sel,
    output logic   taken
);
    logic signed_le;

    assign signed_le = flags.z | (flags.n ^ flags.v);

    always_comb begin
        case (sel)
            CND_ALWAYS: taken = 1'b1;
            CND_NEVER:  taken = 1'b0;
            CND_EQ:     taken = flags.z;
            CND_NE:     taken = ~flags.z;
            CND_GT:     taken = ~signed_le;
            CND_LE:     taken = signed_le;
            CND_CS:     taken = flags.c;
            default:    taken = ~flags.c;
        endcase
    end

endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        cond_sel,
    output logic [DATA_W-1:0] result,
    output logic              store,
    output logic [3:0]        ccr,
    output logic              br_taken
);
    ccr_t              ccr_q;
    ccr_t              ccr_nxt;
    logic [DATA_W-1:0] res_nxt;
    logic [DATA_W-1:0] result_q;
    logic              store_q;
    logic              op_known;
    logic              op_stores;
    logic              accept;

    alu_ccr_core #(.DATA_W(DATA_W)) u_core (
        .op      (alu_op_e'(op_code)),
        .size    (size_e'(op_size)),
        .a       (opnd_a),
        .b       (opnd_b),
        .ccr_in  (ccr_q),
        .res     (res_nxt),
        .ccr_nxt (ccr_nxt),
        .known   (op_known),
        .stores  (op_stores)
    );

    alu_ccr_cond u_cond (
        .flags (ccr_q),
        .sel   (cond_e'(cond_sel)),
        .taken (br_taken)
    );

    assign accept = op_valid && op_known;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_q    <= '0;
            result_q <= '0;
            store_q  <= 1'b0;
        end else begin
            store_q <= accept && op_stores && wr_en;
            if (accept) begin
                ccr_q    <= ccr_nxt;
                result_q <= res_nxt;
            end
        end
    end

    assign result = result_q;
    assign store  = store_q;
    assign ccr    = ccr_q;

endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic        wr_en,
    input logic [31:0] result,
    input logic        store,
    input logic [3:0]  ccr
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(ccr) && $stable(result) && !store)); // R2

    AST_STORE_Z_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> (ccr[2] == (result == 32'd0))); // R3

    AST_CMP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |=> !store); // R6

    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd6 || op_code == 4'd7)) |=> (ccr[0] == $past(ccr[0]))); // R7

    AST_LOGIC_CLEAR_V: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd3 && op_code <= 4'd5) |=> !ccr[1]); // R8

    AST_NO_WE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en) |=> !store); // R9

    AST_CCR_OP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd8 && op_code <= 4'd10) |=> !store); // R10

    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd11) |=> ($stable(ccr) && $stable(result) && !store)); // R12

endmodule

bind alu_ccr alu_ccr_chk u_chk (.*);

// File: tb/alu_ccr_test.sv
module alu_ccr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [1:0]  op_size = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic [31:0] result;
    logic        store;
    logic [3:0]  ccr;
    logic        br_taken;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu_ccr uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .wr_en(wr_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .cond_sel(cond_sel), .result(result), .store(store), .ccr(ccr),
        .br_taken(br_taken)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] b, input logic we);
        @(negedge clk);
        op_code  = op;
        op_size  = sz;
        opnd_a   = a;
        opnd_b   = b;
        wr_en    = we;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] r,
                              input logic st, input logic [3:0] cc);
        check(req, "result", result, r);
        check(req, "store", {31'd0, store}, {31'd0, st});
        check(req, "ccr", {28'd0, ccr}, {28'd0, cc});
    endtask

    task automatic t_reset;
        expect_out("R1", 32'd0, 1'b0, 4'h0);
    endtask

    task automatic t_add;
        run_op(4'd0, 2'd0, 32'h7F, 32'h01, 1'b1);
        expect_out("R4", 32'h80, 1'b1, 4'hA);
        @(negedge clk);
        check("R9", "store drop", {31'd0, store}, 32'd0);
        run_op(4'd0, 2'd0, 32'hFF, 32'h01, 1'b1);
        expect_out("R4", 32'h00, 1'b1, 4'h5);
        run_op(4'd0, 2'd0, 32'hABCD_0180, 32'h0000_0080, 1'b1);
        expect_out("R3", 32'h00, 1'b1, 4'h7);
        run_op(4'd0, 2'd1, 32'h7FFF, 32'h0001, 1'b1);
        expect_out("R4", 32'h8000, 1'b1, 4'hA);
        run_op(4'd0, 2'd1, 32'h1_FFFF, 32'h0002, 1'b1);
        expect_out("R3", 32'h0001, 1'b1, 4'h1);
        run_op(4'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 1'b1);
        expect_out("R4", 32'h0, 1'b1, 4'h5);
        run_op(4'd0, 2'd2, 32'h7FFF_FFFF, 32'h1, 1'b1);
        expect_out("R4", 32'h8000_0000, 1'b1, 4'hA);
        run_op(4'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b1);
        expect_out("R3", 32'h0, 1'b1, 4'h7);
    endtask

    task automatic t_sub;
        run_op(4'd1, 2'd0, 32'h03, 32'h05, 1'b1);
        expect_out("R5", 32'hFE, 1'b1, 4'h9);
        run_op(4'd1, 2'd0, 32'h80, 32'h01, 1'b1);
        expect_out("R5", 32'h7F, 1'b1, 4'h2);
        run_op(4'd1, 2'd2, 32'd5, 32'd3, 1'b1);
        expect_out("R5", 32'd2, 1'b1, 4'h0);
        run_op(4'd1, 2'd2, 32'd3, 32'd5, 1'b1);
        expect_out("R5", 32'hFFFF_FFFE, 1'b1, 4'h9);
    endtask

    task automatic t_cmp;
        run_op(4'd2, 2'd1, 32'h1234, 32'h1234, 1'b1);
        expect_out("R6", 32'h0, 1'b0, 4'h4);
    endtask

    task automatic t_incdec;
        run_op(4'd1, 2'd0, 32'h03, 32'h05, 1'b1);
        expect_out("R7", 32'hFE, 1'b1, 4'h9);
        run_op(4'd6, 2'd0, 32'h7F, 32'h1, 1'b1);
        expect_out("R7", 32'h80, 1'b1, 4'hB);
        run_op(4'd7, 2'd1, 32'h0001, 32'h1, 1'b1);
        expect_out("R7", 32'h0, 1'b1, 4'h5);
        run_op(4'd6, 2'd2, 32'hFFFF_FFFF, 32'h1, 1'b1);
        expect_out("R7", 32'h0, 1'b1, 4'h7);
    endtask

    task automatic t_logic;
        run_op(4'd3, 2'd0, 32'hF0, 32'h3C, 1'b1);
        expect_out("R8", 32'h30, 1'b1, 4'h1);
        run_op(4'd4, 2'd1, 32'h8000, 32'h0001, 1'b1);
        expect_out("R8", 32'h8001, 1'b1, 4'h9);
        run_op(4'd5, 2'd2, 32'hFFFF_0000, 32'hFFFF_0000, 1'b1);
        expect_out("R8", 32'h0, 1'b1, 4'h5);
    endtask

    task automatic t_store_gate;
        run_op(4'd0, 2'd0, 32'h1, 32'h1, 1'b0);
        expect_out("R9", 32'h2, 1'b0, 4'h0);
    endtask

    task automatic t_ccr_imm;
        run_op(4'd9, 2'd0, 32'h0, 32'h0F, 1'b1);
        expect_out("R10", 32'h0F, 1'b0, 4'hF);
        run_op(4'd8, 2'd0, 32'h0, 32'hF5, 1'b1);
        expect_out("R10", 32'h05, 1'b0, 4'h5);
        run_op(4'd10, 2'd0, 32'h0, 32'hFF, 1'b1);
        expect_out("R10", 32'hFA, 1'b0, 4'hA);
    endtask

    task automatic check_cond(input logic [2:0] sel, input logic exp);
        cond_sel = sel;
        #1;
        check("R11", $sformatf("cond %0d", sel), {31'd0, br_taken}, {31'd0, exp});
    endtask

    task automatic t_branch;
        // flags 0xA: N=1 Z=0 V=1 C=0
        check_cond(3'd0, 1'b1);
        check_cond(3'd1, 1'b0);
        check_cond(3'd2, 1'b0);
        check_cond(3'd3, 1'b1);
        check_cond(3'd4, 1'b1);
        check_cond(3'd5, 1'b0);
        check_cond(3'd6, 1'b0);
        check_cond(3'd7, 1'b1);
        run_op(4'd10, 2'd0, 32'h0, 32'h02, 1'b1);
        check("R11", "ccr", {28'd0, ccr}, 32'h8);
        check_cond(3'd4, 1'b0);
        check_cond(3'd5, 1'b1);
        run_op(4'd9, 2'd0, 32'h0, 32'h04, 1'b1);
        check("R11", "ccr", {28'd0, ccr}, 32'hC);
        check_cond(3'd2, 1'b1);
        check_cond(3'd4, 1'b0);
        check_cond(3'd5, 1'b1);
    endtask

    task automatic t_undef_idle;
        run_op(4'd15, 2'd0, 32'h55, 32'h55, 1'b1);
        expect_out("R12", 32'h0C, 1'b0, 4'hC);
        run_op(4'd11, 2'd2, 32'h1, 32'h1, 1'b1);
        expect_out("R12", 32'h0C, 1'b0, 4'hC);
        @(negedge clk);
        op_code = 4'd0; op_size = 2'd0; opnd_a = 32'h1; opnd_b = 32'h1; wr_en = 1'b1;
        op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_out("R2", 32'h0C, 1'b0, 4'hC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_incdec();
        t_logic();
        t_store_gate();
        t_ccr_imm();
        t_branch();
        t_undef_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule